// File: doc/BRIEF.md
# Clock Status Register with Sticky Lock Indication

This block is the status and synthesizer-control register pair of a clock module. While reset is asserted it samples three configuration strap inputs. These say whether the system clock comes from the PLL, whether the PLL multiplies or runs 1:1, and whether the reference is a crystal. The sampled values are held as read-only status bits until the next reset.

The same status word carries a sticky lock indication, derived from a raw lock-detect input. The indication goes high on the first lock only after an arming event. Arming events are a reset, a control write that changes the 3-bit multiplier field, or a stop-mode exit with fast wakeup. Any loss of lock clears the indication. A relock without a new arming event leaves it low, so software can tell that lock was lost at some point.

A small register bus gives access. It has an address, a write enable, write data and combinational read data. Address 0 is the status word. Address 1 is the synthesizer control register.

Top module: `clkstat_reg`

## Requirements
- R1: While `rst_n` is low the straps are captured every clock. Afterwards status bit 0 (`strap_pll_i`), bit 1 (`strap_normal_i`) and bit 2 (`strap_xtal_i`) hold the captured values, whatever the strap inputs do, until the next reset.
- R2: The legal strap combinations, written pll:normal:xtal, are 000, 100, 110 and 111. Each one reads back unchanged as status bits [0], [1] and [2].
- R3: A read of address 0 returns the sticky lock bit in bit 3 and the three strap bits in bits [2:0]; all higher bits read 0. A write to address 0 changes neither status nor control.
- R4: Address 1 is the control register. It is DATA_W bits wide, read/write, and resets to 0. Its multiplier field is bits [6:4] by default. Any other address reads 0.
- R5: After reset, the first clock edge that samples `pll_lock_i` high after it was low sets the sticky bit. The bit is visible from that edge on.
- R6: Any clock edge that samples `pll_lock_i` low clears the sticky bit.
- R7: A relock that follows a lock drop, with no arming event in between, leaves the sticky bit at 0.
- R8: A write to address 1 whose multiplier field differs from the stored one clears the sticky bit and arms it. The next rising edge of lock then sets it.
- R9: A write to address 1 that leaves the multiplier field unchanged neither clears the sticky bit nor arms it.
- R10: A one-cycle pulse on `stop_fastwake_i` clears the sticky bit and arms it.
- R11: If `pll_lock_i` is already high when reset is released, the sticky bit sets on the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_pll_i | input | 1 | Strap: 1 = system clock from PLL, 0 = external clock |
| strap_normal_i | input | 1 | Strap: 1 = multiplying PLL mode, 0 = 1:1 mode |
| strap_xtal_i | input | 1 | Strap: 1 = crystal reference, 0 = external reference |
| pll_lock_i | input | 1 | Raw lock-detect level |
| stop_fastwake_i | input | 1 | One-cycle pulse: stop mode left with fast wakeup |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` |

## Verification
The assertions take for granted that the straps are held at one of the four legal combinations and stay steady for at least two cycles of reset. They also assume that the fast-wakeup input arrives only as a pulse. The bench applies each legal strap pattern for three cycles of reset and changes straps only outside reset. That change targets R1, and the capture properties are gated until one cycle after release, so it does not trip them. Lock, writes and wake pulses are driven a short delay after each clock edge, so the design samples a single clean value per cycle.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;

    // Strap sample; bit order matches the status word, bit 0 = PLL source.
    typedef struct packed {
        logic ref_xtal;
        logic synth_normal;
        logic src_pll;
    } strap_t;

    localparam int STRAP_W      = $bits(strap_t);
    localparam int STAT_LOCK_BIT = STRAP_W;

    typedef struct packed {
        logic armed;
        logic lock_prev;
        logic sticky;
    } lock_state_t;

endpackage

// File: rtl/clkstat_strap_latch.sv
module clkstat_strap_latch
    import clkstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  strap_t strap_i,
    output strap_t strap_o
);

    strap_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d = strap_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign strap_o = cfg_q;

endmodule

// File: rtl/clkstat_ctrl_reg.sv
module clkstat_ctrl_reg #(
    parameter int DATA_W   = 8,
    parameter int MULT_LSB = 4,
    parameter int MULT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              mult_chg_o
);

    localparam int MULT_MSB = MULT_LSB + MULT_W - 1;

    logic [DATA_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        mult_chg_o = rst_n && wr_en_i &&
                     (wdata_i[MULT_MSB:MULT_LSB] != ctrl_q[MULT_MSB:MULT_LSB]);
        ctrl_d = ctrl_q;
        if (!rst_n) begin
            ctrl_d = '0;
        end else if (wr_en_i) begin
            ctrl_d = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/clkstat_lock_track.sv
module clkstat_lock_track
    import clkstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    input  logic rearm_i,
    output logic sticky_o
);

    lock_state_t st_d, st_q;
    logic        lock_rise;

    always_comb begin
        lock_rise       = lock_i & ~st_q.lock_prev;
        st_d            = st_q;
        st_d.lock_prev  = lock_i;
        if (!rst_n) begin
            st_d.armed     = 1'b1;
            st_d.lock_prev = 1'b0;
            st_d.sticky    = 1'b0;
        end else if (rearm_i) begin
            // A new multiplier or a fast wake restarts the lock wait.
            st_d.armed  = 1'b1;
            st_d.sticky = 1'b0;
        end else if (!lock_i) begin
            st_d.sticky = 1'b0;
        end else if (lock_rise && st_q.armed) begin
            st_d.sticky = 1'b1;
            st_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sticky_o = st_q.sticky;

endmodule

// File: rtl/clkstat_reg.sv
module clkstat_reg
    import clkstat_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int MULT_LSB  = 4,
    parameter int MULT_W    = 3,
    parameter int STAT_ADDR = 0,
    parameter int CTRL_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pll_i,
    input  logic              strap_normal_i,
    input  logic              strap_xtal_i,
    input  logic              pll_lock_i,
    input  logic              stop_fastwake_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    strap_t            strap_in, strap_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              ctrl_we;
    logic              mult_chg;
    logic              lock_sticky;
    logic [STRAP_W-1:0] stat_bits;

    assign strap_in.src_pll      = strap_pll_i;
    assign strap_in.synth_normal = strap_normal_i;
    assign strap_in.ref_xtal     = strap_xtal_i;
    assign ctrl_we   = bus_we_i && (bus_addr_i == CTRL_A);
    assign stat_bits = strap_q;

    clkstat_strap_latch u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_in),
        .strap_o (strap_q)
    );

    clkstat_ctrl_reg #(
        .DATA_W   (DATA_W),
        .MULT_LSB (MULT_LSB),
        .MULT_W   (MULT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (ctrl_we),
        .wdata_i    (bus_wdata_i),
        .ctrl_o     (ctrl_q),
        .mult_chg_o (mult_chg)
    );

    clkstat_lock_track u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_i   (pll_lock_i),
        .rearm_i  (mult_chg | stop_fastwake_i),
        .sticky_o (lock_sticky)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == STAT_A) begin
            bus_rdata_o[STRAP_W-1:0]   = stat_bits;
            bus_rdata_o[STAT_LOCK_BIT] = lock_sticky;
        end else if (bus_addr_i == CTRL_A) begin
            bus_rdata_o = ctrl_q;
        end
    end

endmodule

// File: rtl/clkstat_reg_chk.sv
module clkstat_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_lock,
    input logic       sticky,
    input logic [2:0] stat,
    input logic       mult_chg,
    input logic       fast_wake
);

    logic seen_q = 1'b0;
    always_ff @(posedge clk) begin
        seen_q <= rst_n;
    end

    // R1: captured straps never move outside reset
    assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> $stable(stat));

    // R2: only legal combinations reach the status word
    assert_strap_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stat == 3'b000 || stat == 3'b001 ||
                    stat == 3'b011 || stat == 3'b111));

    // R5: the sticky bit rises only from a sampled lock with no rearm
    assert_set_on_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(sticky)) |-> ($past(pll_lock) && !$past(mult_chg) && !$past(fast_wake)));

    // R6: lock low clears the bit
    assert_drop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock |=> !sticky);

    // R8: multiplier change clears the bit
    assert_mult_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mult_chg |=> !sticky);

    // R10: fast wake clears the bit
    assert_wake_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fast_wake |=> !sticky);

endmodule

bind clkstat_reg clkstat_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_lock  (pll_lock_i),
    .sticky    (lock_sticky),
    .stat      (stat_bits),
    .mult_chg  (mult_chg),
    .fast_wake (stop_fastwake_i)
);

// File: tb/sim_clkstat_reg.sv
module sim_clkstat_reg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_pll = 1'b0, s_norm = 1'b0, s_xtal = 1'b0;
    logic              lock = 1'b0;
    logic              fwake = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clkstat_reg u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_pll_i     (s_pll),
        .strap_normal_i  (s_norm),
        .strap_xtal_i    (s_xtal),
        .pll_lock_i      (lock),
        .stop_fastwake_i (fwake),
        .bus_addr_i      (addr),
        .bus_we_i        (we),
        .bus_wdata_i     (wdata),
        .bus_rdata_o     (rdata)
    );

    // {lock, we, wdata[7:0], expected sticky}
    localparam logic [10:0] VEC [13] = '{
        {1'b1, 1'b0, 8'h00, 1'b1},  // R5 first lock
        {1'b1, 1'b0, 8'h00, 1'b1},  // R5 hold
        {1'b0, 1'b0, 8'h00, 1'b0},  // R6 drop
        {1'b1, 1'b0, 8'h00, 1'b0},  // R7 relock
        {1'b1, 1'b1, 8'h05, 1'b0},  // R9 same field
        {1'b0, 1'b0, 8'h00, 1'b0},  // R6
        {1'b1, 1'b0, 8'h00, 1'b0},  // R9 not armed
        {1'b1, 1'b1, 8'h35, 1'b0},  // R8 change clears
        {1'b1, 1'b0, 8'h00, 1'b0},  // R8 no edge
        {1'b0, 1'b0, 8'h00, 1'b0},  // R6
        {1'b1, 1'b0, 8'h00, 1'b1},  // R8 armed lock
        {1'b1, 1'b1, 8'h3F, 1'b1},  // R9 same field keeps
        {1'b1, 1'b0, 8'h00, 1'b1}   // R9
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:       return "R5";
            2, 5, 9:    return "R6";
            3:          return "R7";
            7, 8, 10:   return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_at(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        we = 1'b0;
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(logic l, logic w, logic [DATA_W-1:0] wd);
        lock = l;
        we = w;
        addr = 4'd1;
        wdata = wd;
        @(posedge clk);
        #1;
        we = 1'b0;
        addr = 4'd0;
        #1;
    endtask

    task automatic do_reset(logic [2:0] straps, logic l);
        rst_n = 1'b0;
        {s_xtal, s_norm, s_pll} = straps;
        lock = l;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        #2;
        do_reset(3'b111, 1'b0);
        read_at(4'd0, d); check("R1 reset status", d, 8'h07);
        read_at(4'd1, d); check("R4 ctrl reset", d, 8'h00);

        {s_xtal, s_norm, s_pll} = 3'b000;
        step(1'b0, 1'b0, 8'h00);
        read_at(4'd0, d); check("R1 straps ignored after reset", d, 8'h07);

        for (int i = 0; i < 13; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8:1]);
            read_at(4'd0, d);
            check(vec_tag(i), {7'd0, d[3]}, {7'd0, VEC[i][0]});
        end

        // R3: writes to the status address are ignored
        lock = 1'b1; addr = 4'd0; we = 1'b1; wdata = 8'hFF;
        @(posedge clk); #1; we = 1'b0;
        read_at(4'd0, d); check("R3 status unchanged", d, 8'h0F);
        read_at(4'd1, d); check("R3 ctrl unchanged", d, 8'h3F);
        read_at(4'd2, d); check("R4 unused address", d, 8'h00);

        // R10: fast wake clears and re-arms
        fwake = 1'b1;
        step(1'b1, 1'b0, 8'h00);
        fwake = 1'b0;
        read_at(4'd0, d); check("R10 wake clears", {7'd0, d[3]}, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        read_at(4'd0, d); check("R10 rearmed lock", {7'd0, d[3]}, 8'h01);

        // R2 / R11: other legal straps, lock high through reset
        do_reset(3'b011, 1'b1);
        read_at(4'd0, d); check("R2 normal ext ref", d, 8'h03);
        @(posedge clk); #1;
        read_at(4'd0, d); check("R11 lock at release", d, 8'h0B);

        do_reset(3'b001, 1'b0);
        read_at(4'd0, d); check("R2 one-to-one", d, 8'h01);
        do_reset(3'b000, 1'b0);
        read_at(4'd0, d); check("R2 external clock", d, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule